// File: doc/BRIEF.md
# Dimension-Ordered Mesh Packet Router

This block is the routing node of a two-dimensional mesh on-chip network. It has five packet ports: four that face the neighbouring nodes (north, south, east, west) and one that faces the local hub. Each packet is 136 bits wide and moves as a single beat. The router reads the destination row and column from the packet's address field and compares them with its own row and column, which are fixed by parameters. It then picks one output by a static dimension-ordered rule. The column is corrected first, along the north/south axis. The row is corrected only after that, along the east/west axis. A packet that has reached its node goes to the hub.

Each output has a five-way round-robin arbiter and a one-entry packet register. Every port uses valid/ready handshaking, and a beat transfers on a rising edge where both valid and ready are high. A sender must hold valid and the packet stable until ready is seen. The router's input ready reflects the downstream ready combinationally. A stalled output therefore pushes back on its sender in the same cycle, and no packet is dropped or duplicated. Input ready is meaningful only while the matching valid is high.

Packet layout: bits [135:128] control, bits [127:64] address, bits [63:0] data. In a read request the data field carries the return address. The destination row is address bits [ROW_LSB +: COORD_W] and the destination column is address bits [COL_LSB +: COORD_W], both above the 20-bit offset within a region. Port indices are 0 north, 1 south, 2 east, 3 west, 4 hub.

Top module: `mesh_router`

## Requirements
- R1: A packet leaves the router with all 136 bits unchanged, including the data field when it carries a read return address.
- R2: If the destination column differs from MY_COL, the packet leaves on north (port 0) when the column is smaller and on south (port 1) when it is larger, whatever the row.
- R3: If the column matches and the destination row differs from MY_ROW, the packet leaves on east (port 2) when the row is larger and on west (port 3) when it is smaller.
- R4: If both the row and the column match, the packet leaves on the hub port (port 4).
- R5: A packet accepted on a rising edge is shown on its output's valid and data from that edge on.
- R6: While an output's valid is high and its ready is low, that output's valid and data stay unchanged.
- R7: An output register takes a new packet when it is empty, or in the same cycle that its current packet leaves. When it is full and stalled, every input aimed at it sees ready low.
- R8: Each output's round-robin pointer is 0 after reset. The winner is the first requesting input at or after the pointer, in cyclic order 0..4. The pointer moves to the input after the winner only when a packet is accepted.
- R9: An input that loses arbitration sees ready low. No packet is lost or duplicated, and order is kept between any one input and any one output.
- R10: During reset, and right after it, all output valids are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 5 | Per input port: packet present |
| in_ready | output | 5 | Per input port: packet accepted at this edge |
| in_data | input | 680 | Five packets, input p at bits [p*136 +: 136] |
| out_valid | output | 5 | Per output port: packet register full |
| out_ready | input | 5 | Per output port: downstream can take the packet |
| out_data | output | 680 | Five packets, output p at bits [p*136 +: 136] |

## Verification
Some properties are checked on every cycle: each full output holds a destination that agrees with its direction, each output accepts at most one input per cycle, a stalled output keeps its packet stable, an accept makes the output valid one edge later, and an arbiter pointer moves only on an accept. Other behaviour can only be shown by the bench's scenarios. These are the exact round-robin order after reset, including wrap-around; the column-first choice for packets whose row also differs; the same-cycle refill of a draining register; and, under random traffic and random stalls, end-to-end delivery with no loss or duplication and with per-pair ordering.

// File: rtl/mesh_rtr_pkg.sv
package mesh_rtr_pkg;
  localparam int NPORT  = 5;
  localparam int DATA_W = 64;
  localparam int ADDR_W = 64;
  localparam int CTRL_W = 8;
  localparam int PKT_W  = DATA_W + ADDR_W + CTRL_W;
  localparam int ADDR_LO = DATA_W;   // address field starts above data
  localparam int PIDX_W = $clog2(NPORT);

  typedef enum logic [PIDX_W-1:0] {
    DIR_NORTH = 3'd0,
    DIR_SOUTH = 3'd1,
    DIR_EAST  = 3'd2,
    DIR_WEST  = 3'd3,
    DIR_HUB   = 3'd4
  } dir_e;
endpackage

// File: rtl/route_calc.sv
module route_calc
  import mesh_rtr_pkg::*;
#(
  parameter int COORD_W = 6,
  parameter int MY_ROW  = 0,
  parameter int MY_COL  = 0
) (
  input  logic [COORD_W-1:0] dst_row,
  input  logic [COORD_W-1:0] dst_col,
  output dir_e               dir
);
  localparam logic [COORD_W-1:0] ROW_V = MY_ROW[COORD_W-1:0];
  localparam logic [COORD_W-1:0] COL_V = MY_COL[COORD_W-1:0];

  // column is corrected first (north/south), then row (east/west)
  always_comb begin
    if (dst_col < COL_V)      dir = DIR_NORTH;
    else if (dst_col > COL_V) dir = DIR_SOUTH;
    else if (dst_row > ROW_V) dir = DIR_EAST;
    else if (dst_row < ROW_V) dir = DIR_WEST;
    else                      dir = DIR_HUB;
  end
endmodule

// File: rtl/rr_arb.sv
module rr_arb #(
  parameter int N = 5,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         advance,
  output logic [N-1:0] grant
);
  logic [PW-1:0] ptr;
  logic [PW-1:0] win;

  always_comb begin
    int idx;
    logic found;
    grant = '0;
    win   = ptr;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      idx = int'(ptr) + k;
      if (idx >= N) idx = idx - N;
      if (!found && req[idx]) begin
        found      = 1'b1;
        grant[idx] = 1'b1;
        win        = PW'(idx);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr <= '0;
    else if (advance) ptr <= (int'(win) == N-1) ? '0 : win + 1'b1;
  end

  p_grant_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  p_grant_in_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0);
  p_ptr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(ptr));
endmodule

// File: rtl/out_slot.sv
module out_slot #(
  parameter int W = 136
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         take,
  output logic         full,
  output logic         can_take,
  output logic [W-1:0] data
);
  assign can_take = !full || take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (load) begin
      full <= 1'b1;
      data <= load_data;
    end else if (take) begin
      full <= 1'b0;
    end
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !take) |=> (full && $stable(data)));
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> can_take);
endmodule

// File: rtl/mesh_router.sv
module mesh_router
  import mesh_rtr_pkg::*;
#(
  parameter int COORD_W = 6,
  parameter int ROW_LSB = 20,
  parameter int COL_LSB = 26,
  parameter int MY_ROW  = 5,
  parameter int MY_COL  = 9
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPORT-1:0]       in_valid,
  output logic [NPORT-1:0]       in_ready,
  input  logic [NPORT*PKT_W-1:0] in_data,
  output logic [NPORT-1:0]       out_valid,
  input  logic [NPORT-1:0]       out_ready,
  output logic [NPORT*PKT_W-1:0] out_data
);
  localparam int ROW_BIT = ADDR_LO + ROW_LSB;
  localparam int COL_BIT = ADDR_LO + COL_LSB;
  localparam logic [COORD_W-1:0] ROW_V = MY_ROW[COORD_W-1:0];
  localparam logic [COORD_W-1:0] COL_V = MY_COL[COORD_W-1:0];

  dir_e             dir      [NPORT];
  logic [NPORT-1:0] req      [NPORT];
  logic [NPORT-1:0] gnt      [NPORT];
  logic [PKT_W-1:0] ld_data  [NPORT];
  logic [NPORT-1:0] can_take;
  logic [NPORT-1:0] acc;

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    route_calc #(.COORD_W(COORD_W), .MY_ROW(MY_ROW), .MY_COL(MY_COL)) u_route (
      .dst_row (in_data[i*PKT_W + ROW_BIT +: COORD_W]),
      .dst_col (in_data[i*PKT_W + COL_BIT +: COORD_W]),
      .dir     (dir[i])
    );
    assign in_ready[i] = can_take[int'(dir[i])] && gnt[int'(dir[i])][i];
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    for (genvar i = 0; i < NPORT; i++) begin : g_req
      assign req[o][i] = in_valid[i] && (int'(dir[i]) == o);
    end

    assign acc[o] = (|req[o]) && can_take[o];

    always_comb begin
      ld_data[o] = '0;
      for (int i = 0; i < NPORT; i++)
        if (gnt[o][i]) ld_data[o] = ld_data[o] | in_data[i*PKT_W +: PKT_W];
    end

    rr_arb #(.N(NPORT)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req[o]),
      .advance (acc[o]),
      .grant   (gnt[o])
    );

    out_slot #(.W(PKT_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (acc[o]),
      .load_data (ld_data[o]),
      .take      (out_ready[o]),
      .full      (out_valid[o]),
      .can_take  (can_take[o]),
      .data      (out_data[o*PKT_W +: PKT_W])
    );

    // checks across the routing stage and the output register
    logic [COORD_W-1:0] q_row, q_col;
    assign q_row = out_data[o*PKT_W + ROW_BIT +: COORD_W];
    assign q_col = out_data[o*PKT_W + COL_BIT +: COORD_W];

    p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
      acc[o] |=> out_valid[o]);
    p_one_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(in_valid & in_ready & req[o]));

    if (o == 0) begin : g_n
      p_north_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[o] |-> (q_col < COL_V));
    end else if (o == 1) begin : g_s
      p_south_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[o] |-> (q_col > COL_V));
    end else if (o == 2) begin : g_e
      p_east_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[o] |-> (q_col == COL_V && q_row > ROW_V));
    end else if (o == 3) begin : g_w
      p_west_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[o] |-> (q_col == COL_V && q_row < ROW_V));
    end else begin : g_h
      p_hub_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[o] |-> (q_col == COL_V && q_row == ROW_V));
    end
  end

  p_reset_idle_r10: assert property (@(posedge clk)
    !rst_n |=> (out_valid == '0));
endmodule

// File: tb/test_mesh_router.sv
module test_mesh_router;
  localparam int NP  = 5;
  localparam int PW  = 136;
  localparam int CW  = 3;
  localparam int RL  = 20;
  localparam int CL  = 23;
  localparam int MR  = 3;
  localparam int MC  = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NP-1:0]     in_valid = '0;
  logic [NP-1:0]     in_ready;
  logic [NP*PW-1:0]  in_data = '0;
  logic [NP-1:0]     out_valid;
  logic [NP-1:0]     out_ready = '1;
  logic [NP*PW-1:0]  out_data;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [PW-1:0] sb [25][$];

  always #5 clk = ~clk;

  mesh_router #(.COORD_W(CW), .ROW_LSB(RL), .COL_LSB(CL), .MY_ROW(MR), .MY_COL(MC)) i_mesh_router (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

  task automatic chk(bit ok, string req, logic [PW-1:0] act, logic [PW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] mk(int src, int drow, int dcol);
    logic [63:0] a, d;
    logic [7:0] c;
    a = {$urandom, $urandom};
    a[RL +: CW] = CW'(drow);
    a[CL +: CW] = CW'(dcol);
    d = {$urandom, $urandom};
    d[2:0] = 3'(src);
    c = 8'($urandom);
    return {c, a, d};
  endfunction

  // expected port from the routing rule (R2, R3, R4)
  function automatic int exp_port(logic [PW-1:0] p);
    int r, c;
    r = int'(p[64 + RL +: CW]);
    c = int'(p[64 + CL +: CW]);
    if (c < MC) return 0;
    if (c > MC) return 1;
    if (r > MR) return 2;
    if (r < MR) return 3;
    return 4;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = '0; out_ready = '1;
    repeat (2) @(negedge clk);
    chk(out_valid == '0, "R10 idle in reset", PW'(out_valid), '0);
    rst_n = 1'b1;
  endtask

  task automatic drive_one(int src, logic [PW-1:0] p, int ep, string req);
    @(negedge clk);
    in_valid = '0; in_valid[src] = 1'b1; in_data[src*PW +: PW] = p; out_ready = '1;
    #4;
    chk(in_ready[src] == 1'b1, "R5 accept", PW'(in_ready), PW'(1 << src));
    @(negedge clk);
    in_valid = '0;
    chk(out_valid == NP'(1 << ep), req, PW'(out_valid), PW'(1 << ep));
    chk(out_data[ep*PW +: PW] == p, "R1 unchanged", out_data[ep*PW +: PW], p);
  endtask

  task automatic sample_outputs();
    for (int o = 0; o < NP; o++) begin
      if (out_valid[o] && out_ready[o]) begin
        logic [PW-1:0] got, ex;
        int src;
        got = out_data[o*PW +: PW];
        src = int'(got[2:0]);
        if (src > 4 || sb[o*5 + src].size() == 0) begin
          chk(1'b0, "R9 R2 unexpected packet", got, '0);
        end else begin
          ex = sb[o*5 + src].pop_front();
          chk(got == ex, "R9 order", got, ex);
        end
      end
    end
  endtask

  initial begin
    logic [PW-1:0] pk [NP];
    logic [PW-1:0] cur [NP];
    bit held [NP];
    int win, lose, left;
    void'($urandom(32'd2024));

    do_reset();
    chk(out_valid == '0, "R10 idle after reset", PW'(out_valid), '0);

    // directed routing, column first even when row also differs
    drive_one(0, mk(0, 6, 1), 0, "R2 north");
    drive_one(1, mk(1, 0, 7), 1, "R2 south");
    drive_one(2, mk(2, 5, MC), 2, "R3 east");
    drive_one(3, mk(3, 0, MC), 3, "R3 west");
    drive_one(4, mk(4, MR, MC), 4, "R4 hub");
    drive_one(1, mk(1, MR, MC), 4, "R4 hub from south");

    // stall on hub output
    @(negedge clk);
    pk[0] = mk(0, MR, MC); pk[1] = mk(1, MR, MC);
    out_ready = 5'b01111;
    in_data[0 +: PW] = pk[0]; in_data[PW +: PW] = pk[1]; in_valid = 5'b00011;
    #4;
    chk($countones(in_ready & in_valid) == 1, "R9 one winner", PW'(in_ready), '0);
    win = in_ready[0] ? 0 : 1; lose = 1 - win;
    @(negedge clk);
    in_valid[win] = 1'b0;
    chk(out_valid[4] && out_data[4*PW +: PW] == pk[win], "R5 hub loaded", out_data[4*PW +: PW], pk[win]);
    #4;
    chk(in_ready[lose] == 1'b0, "R7 full and stalled", PW'(in_ready), '0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(out_valid[4] && out_data[4*PW +: PW] == pk[win], "R6 hold", out_data[4*PW +: PW], pk[win]);
    end
    @(negedge clk);
    out_ready = '1;
    #4;
    chk(in_ready[lose] == 1'b1, "R7 refill while draining", PW'(in_ready), PW'(1 << lose));
    @(negedge clk);
    in_valid = '0;
    chk(out_valid[4] && out_data[4*PW +: PW] == pk[lose], "R7 second packet", out_data[4*PW +: PW], pk[lose]);
    @(negedge clk);
    chk(out_valid == '0, "R6 drained", PW'(out_valid), '0);

    // round robin from a fresh reset
    do_reset();
    @(negedge clk);
    for (int i = 0; i < NP; i++) begin
      pk[i] = mk(i, MR, MC); in_data[i*PW +: PW] = pk[i];
    end
    in_valid = '1;
    for (int s = 0; s < NP; s++) begin
      #4;
      chk(in_ready == NP'(1 << s), "R8 order from zero", PW'(in_ready), PW'(1 << s));
      @(negedge clk);
      in_valid[s] = 1'b0;
    end
    in_valid = 5'b01000;
    #4;
    chk(in_ready == 5'b01000, "R8 single requester", PW'(in_ready), PW'(8));
    @(negedge clk);
    in_valid = 5'b10011;
    #4;
    chk(in_ready == 5'b10000, "R8 after pointer", PW'(in_ready), PW'(16));
    @(negedge clk);
    in_valid[4] = 1'b0;
    #4;
    chk(in_ready == 5'b00001, "R8 wrap", PW'(in_ready), PW'(1));
    @(negedge clk);
    in_valid[0] = 1'b0;
    #4;
    chk(in_ready == 5'b00010, "R8 next", PW'(in_ready), PW'(2));
    @(negedge clk);
    in_valid = '0;
    repeat (2) @(negedge clk);

    // random traffic with random stalls
    for (int i = 0; i < NP; i++) held[i] = 0;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      for (int o = 0; o < NP; o++) out_ready[o] = ($urandom % 4) != 0;
      for (int i = 0; i < NP; i++) begin
        if (!held[i] && ($urandom % 3) == 0) begin
          cur[i] = mk(i, int'($urandom % 8), int'($urandom % 8));
          held[i] = 1;
        end
        in_valid[i] = held[i];
        in_data[i*PW +: PW] = cur[i];
      end
      #4;
      for (int i = 0; i < NP; i++) begin
        if (in_valid[i] && in_ready[i]) begin
          sb[exp_port(cur[i])*5 + i].push_back(cur[i]);
          held[i] = 0;
        end
      end
      sample_outputs();
    end
    @(negedge clk);
    in_valid = '0; out_ready = '1;
    for (int k = 0; k < 10; k++) begin
      #4;
      sample_outputs();
      @(negedge clk);
    end
    left = 0;
    for (int q = 0; q < 25; q++) left += sb[q].size();
    chk(left == 0, "R9 nothing lost", PW'(left), '0);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule